// File: doc/BRIEF.md
# Daisy-Chain Serial Command Master

This block is the host-side driver for a string of identical serial converter devices. All devices share one serial clock and one active-low select line. The data line passes through each device in turn. For each transaction the block takes one command, address and data tuple per device, plus a per-device select mask. It builds one 32-bit frame for each device and shifts all frames out as a single stream while select is held low. It then raises select so that every device executes its frame at the same moment.

While shifting, the block samples the data returned from the far end of the chain. That data is the stream left in the chain by the previous transaction, and it is presented as a readback vector for integrity checking. The serial clock is derived from the system clock by a parameterised half-period divider. The lead, trail and idle-high intervals of the select line are parameters.

Requests arrive on a valid/ready pair. `req_ready` is high only while the block is idle, and the request fields are captured on the cycle where both `req_valid` and `req_ready` are high. The readback leaves on `rd_valid` with no back-pressure: `rd_valid` pulses for one cycle, and `rd_frames` holds its value until the next request is accepted.

Top module: `dac_chain_master`

## Requirements
- R1: After reset `cs_n` is 1, `sck` is 0, `busy` is 0, `req_ready` is 1, and `done` and `rd_valid` are 0.
- R2: The frame for device i is 32 bits sent MSB first: eight zero pad bits, then the 4-bit command, then the 4-bit address, then the 16 data bits. Device i's fields sit at bits [4i+3:4i] of `dev_cmd` and `dev_addr` and at bits [16i+15:16i] of `dev_data`.
- R3: The frame for device N_DEV-1, the farthest from the master, is shifted first, and the frame for device 0 is shifted last. After the transaction, device i holds its own frame.
- R4: A device whose `dev_sel` bit is 0 receives command code 4'b1111 (no operation) in place of its `dev_cmd` field. Its address and data fields are sent unchanged.
- R5: Each transaction gives exactly N_DEV*32 rising `sck` edges while `cs_n` is low. `sck` is 0 whenever `cs_n` is 1.
- R6: `sdi` changes only while `sck` is low. It is stable for the whole of each `sck` high phase.
- R7: `cs_n` is low for exactly LEAD_CYC clock cycles before the first `sck` rise. It stays low for exactly TRAIL_CYC cycles after the last `sck` fall. It then stays high for GAP_CYC cycles before `busy` drops.
- R8: Every `sck` high phase, and every `sck` low phase between two rising edges, lasts exactly DIV_HALF clock cycles.
- R9: A request is accepted only when `req_valid` and `req_ready` are both 1, and `req_ready` equals `!busy`. `cs_n` is low on the cycle after acceptance. `req_valid` asserted while busy neither alters the running transaction nor starts another.
- R10: At the end of a transaction, `done` and `rd_valid` pulse together for one cycle, in the cycle where `busy` falls. `rd_frames` then holds the N_DEV*32 bits sampled from `sdo` at each `sck` rise, with the first sampled bit at the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| dev_sel | input | N_DEV | Per-device target mask |
| dev_cmd | input | 4*N_DEV | Per-device command codes |
| dev_addr | input | 4*N_DEV | Per-device address codes |
| dev_data | input | 16*N_DEV | Per-device data words |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_valid | output | 1 | Readback vector valid pulse |
| rd_frames | output | 32*N_DEV | Stream returned from chain end |
| sck | output | 1 | Serial clock to all devices |
| sdi | output | 1 | Serial data into the first device |
| cs_n | output | 1 | Shared active-low select/load |
| sdo | input | 1 | Serial data from the last device |

## Verification
The assertions assume that `rst_n` is held low across at least one clock edge, and that `sdo` changes only as a chained device would change it, on `sck` falling edges. The bench honours both assumptions. It drives `sdo` from a behavioural chain of N_DEV shift registers that shift on `sck` rising edges and update their outputs on falling edges. The bench changes `req_valid` and the request fields only on falling clock edges. It raises a request during a running transaction only to test that the request is ignored.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int FRAME_W = 32;
  localparam int PAD_W   = 8;
  localparam int CMD_W   = 4;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam logic [CMD_W-1:0] CMD_NOP = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL,
    ST_GAP
  } seq_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/dcm_frame_builder.sv
module dcm_frame_builder
  import dcm_pkg::*;
#(
  parameter int N_DEV = 3,
  localparam int STREAM_W = N_DEV * FRAME_W
) (
  input  logic [N_DEV-1:0]        sel,
  input  logic [N_DEV*CMD_W-1:0]  cmd,
  input  logic [N_DEV*ADDR_W-1:0] addr,
  input  logic [N_DEV*DATA_W-1:0] data,
  output logic [STREAM_W-1:0]     stream
);
  // Device g occupies slice g; the highest slice leaves first.
  for (genvar g = 0; g < N_DEV; g++) begin : g_frame
    logic [CMD_W-1:0] eff_cmd;
    assign eff_cmd = sel[g] ? cmd[g*CMD_W +: CMD_W] : CMD_NOP;
    assign stream[g*FRAME_W +: FRAME_W] =
      {{PAD_W{1'b0}}, eff_cmd, addr[g*ADDR_W +: ADDR_W], data[g*DATA_W +: DATA_W]};
  end
endmodule

// File: rtl/dcm_seq.sv
module dcm_seq
  import dcm_pkg::*;
#(
  parameter int N_BITS    = 96,
  parameter int DIV_HALF  = 2,
  parameter int LEAD_CYC  = 2,
  parameter int TRAIL_CYC = 2,
  parameter int GAP_CYC   = 3,
  localparam int CNT_MAX  = max4(DIV_HALF, LEAD_CYC, TRAIL_CYC, GAP_CYC),
  localparam int CNT_W    = $clog2(CNT_MAX + 1),
  localparam int BIT_W    = $clog2(N_BITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic shift,
  output logic sample,
  output logic busy,
  output logic done,
  output logic sck,
  output logic cs_n
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitc;

  logic lead_end, half_end, trail_end, gap_end, last_bit;
  assign lead_end  = (cnt == CNT_W'(LEAD_CYC - 1));
  assign half_end  = (cnt == CNT_W'(DIV_HALF - 1));
  assign trail_end = (cnt == CNT_W'(TRAIL_CYC - 1));
  assign gap_end   = (cnt == CNT_W'(GAP_CYC - 1));
  assign last_bit  = (bitc == BIT_W'(N_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      bitc  <= '0;
      sck   <= 1'b0;
      cs_n  <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_LEAD;
          cnt   <= '0;
          bitc  <= '0;
          cs_n  <= 1'b0;
        end
        ST_LEAD: if (lead_end) begin
          cnt   <= '0;
          sck   <= 1'b1;
          state <= ST_HIGH;
        end else cnt <= cnt + 1'b1;
        ST_HIGH: if (half_end) begin
          cnt  <= '0;
          sck  <= 1'b0;
          bitc <= bitc + 1'b1;
          state <= last_bit ? ST_TRAIL : ST_LOW;
        end else cnt <= cnt + 1'b1;
        ST_LOW: if (half_end) begin
          cnt   <= '0;
          sck   <= 1'b1;
          state <= ST_HIGH;
        end else cnt <= cnt + 1'b1;
        ST_TRAIL: if (trail_end) begin
          cnt   <= '0;
          cs_n  <= 1'b1;
          state <= ST_GAP;
        end else cnt <= cnt + 1'b1;
        ST_GAP: if (gap_end) begin
          cnt   <= '0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign load   = (state == ST_IDLE) && start;
  assign sample = ((state == ST_LEAD) && lead_end) || ((state == ST_LOW) && half_end);
  assign shift  = (state == ST_HIGH) && half_end && !last_bit;
endmodule

// File: rtl/dcm_shifter.sv
module dcm_shifter #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  input  logic         sample,
  input  logic         sdo,
  output logic         sdi,
  output logic [W-1:0] rx_data
);
  logic [W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_data <= '0;
    end else begin
      if (load)       tx_q <= load_data;
      else if (shift) tx_q <= {tx_q[W-2:0], 1'b0};
      if (sample)     rx_data <= {rx_data[W-2:0], sdo};
    end
  end

  assign sdi = tx_q[W-1];
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master
  import dcm_pkg::*;
#(
  parameter int N_DEV     = 3,
  parameter int DIV_HALF  = 2,
  parameter int LEAD_CYC  = 2,
  parameter int TRAIL_CYC = 2,
  parameter int GAP_CYC   = 3,
  localparam int STREAM_W = N_DEV * FRAME_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [N_DEV-1:0]        dev_sel,
  input  logic [N_DEV*CMD_W-1:0]  dev_cmd,
  input  logic [N_DEV*ADDR_W-1:0] dev_addr,
  input  logic [N_DEV*DATA_W-1:0] dev_data,
  output logic                    busy,
  output logic                    done,
  output logic                    rd_valid,
  output logic [STREAM_W-1:0]     rd_frames,
  output logic                    sck,
  output logic                    sdi,
  output logic                    cs_n,
  input  logic                    sdo
);
  logic [STREAM_W-1:0] stream;
  logic load, shift, sample;

  dcm_frame_builder #(.N_DEV(N_DEV)) u_build (
    .sel(dev_sel), .cmd(dev_cmd), .addr(dev_addr), .data(dev_data), .stream(stream)
  );

  dcm_seq #(
    .N_BITS(STREAM_W), .DIV_HALF(DIV_HALF), .LEAD_CYC(LEAD_CYC),
    .TRAIL_CYC(TRAIL_CYC), .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_valid), .load(load), .shift(shift),
    .sample(sample), .busy(busy), .done(done), .sck(sck), .cs_n(cs_n)
  );

  dcm_shifter #(.W(STREAM_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(stream), .shift(shift),
    .sample(sample), .sdo(sdo), .sdi(sdi), .rx_data(rd_frames)
  );

  assign req_ready = !busy;
  assign rd_valid  = done;
endmodule

// File: rtl/dac_chain_master_chk.sv
module dac_chain_master_chk #(
  parameter int N_DEV     = 3,
  parameter int LEAD_CYC  = 2,
  parameter int TRAIL_CYC = 2,
  localparam int N_BITS   = N_DEV * 32,
  localparam int RC_W     = $clog2(N_BITS + 1) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic sck,
  input logic sdi,
  input logic cs_n
);
  logic            sck_q;
  logic [RC_W-1:0] rise_cnt;
  logic [15:0]     low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      rise_cnt <= '0;
      low_run  <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) rise_cnt <= '0;
      else if (sck && !sck_q) rise_cnt <= rise_cnt + 1'b1;
      if (cs_n || sck) low_run <= '0;
      else low_run <= low_run + 1'b1;
    end
  end

  // R5: sck idles low while select is high
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R5: exact edge count per transaction
  p_edges_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n)) |-> (rise_cnt == RC_W'(N_BITS)));
  // R6: data stable while sck high
  p_sdi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdi));
  // R7: lead interval before the first rise
  p_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && !sck_q && rise_cnt == '0) |-> (low_run >= 16'(LEAD_CYC)));
  // R7: trail interval before select rises
  p_trail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n)) |-> (low_run >= 16'(TRAIL_CYC)));
  // R9: acceptance starts a transaction
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !cs_n));
  // R10: done is a single pulse ending busy
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind dac_chain_master dac_chain_master_chk #(
  .N_DEV(N_DEV), .LEAD_CYC(LEAD_CYC), .TRAIL_CYC(TRAIL_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .sck(sck), .sdi(sdi), .cs_n(cs_n)
);

// File: tb/test_dac_chain_master.sv
module test_dac_chain_master;
  localparam int N     = 3;
  localparam int DIV   = 2;
  localparam int LEAD  = 2;
  localparam int TRAIL = 2;
  localparam int GAP   = 3;
  localparam int SW    = N * 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [N-1:0] dev_sel = '0;
  logic [N*4-1:0] dev_cmd = '0, dev_addr = '0;
  logic [N*16-1:0] dev_data = '0;
  logic req_ready, busy, done, rd_valid, sck, sdi, cs_n, sdo;
  logic [SW-1:0] rd_frames;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  dac_chain_master #(.N_DEV(N), .DIV_HALF(DIV), .LEAD_CYC(LEAD), .TRAIL_CYC(TRAIL),
    .GAP_CYC(GAP)) i_dac_chain_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .dev_sel(dev_sel), .dev_cmd(dev_cmd), .dev_addr(dev_addr), .dev_data(dev_data),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_frames(rd_frames),
    .sck(sck), .sdi(sdi), .cs_n(cs_n), .sdo(sdo));

  // Behavioural device chain: shift on rise, drive on fall, execute on select rise
  logic [31:0] dreg [N];
  logic [31:0] dexec [N];
  logic        dsdo [N];
  initial for (int i = 0; i < N; i++) begin dreg[i] = '0; dexec[i] = '0; dsdo[i] = 1'b0; end
  always @(posedge sck) if (!cs_n)
    for (int i = 0; i < N; i++) dreg[i] <= {dreg[i][30:0], (i == 0) ? sdi : dsdo[(i == 0) ? 0 : i-1]};
  always @(negedge sck) for (int i = 0; i < N; i++) dsdo[i] <= dreg[i][31];
  always @(posedge cs_n) for (int i = 0; i < N; i++) dexec[i] <= dreg[i];
  assign sdo = dsdo[N-1];

  // Timing monitor sampled on falling clock edges
  int rises = 0, sdi_viol = 0, tim_bad = 0, lowrun = 0, highrun = 0, gaprun = 0;
  logic p_sck = 1'b0, p_sdi = 1'b0, p_cs = 1'b1, p_busy = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n && p_cs) rises = 0;
    if (sck && p_sck && sdi !== p_sdi) sdi_viol++;
    if (sck && !p_sck) begin
      if (rises == 0 ? lowrun != LEAD : lowrun != DIV) tim_bad++;
      rises++;
    end
    if (!sck && p_sck && highrun != DIV) tim_bad++;
    if (cs_n && !p_cs && lowrun != TRAIL) tim_bad++;
    if (!busy && p_busy && gaprun != GAP) tim_bad++;
    highrun = sck ? highrun + 1 : 0;
    lowrun  = (!cs_n && !sck) ? lowrun + 1 : 0;
    gaprun  = (cs_n && busy) ? gaprun + 1 : 0;
    p_sck = sck; p_sdi = sdi; p_cs = cs_n; p_busy = busy;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] frame(input logic s, input logic [3:0] c,
                                        input logic [3:0] a, input logic [15:0] d);
    return {8'h00, s ? c : 4'hF, a, d};
  endfunction

  function automatic logic [SW-1:0] stream_of();
    logic [SW-1:0] s;
    for (int i = 0; i < N; i++)
      s[i*32 +: 32] = frame(dev_sel[i], dev_cmd[i*4 +: 4], dev_addr[i*4 +: 4], dev_data[i*16 +: 16]);
    return s;
  endfunction

  logic [SW-1:0] exp_stream, prev_stream = '0;
  int rd_seen = 0;

  task automatic run_txn();
    int t = 0;
    exp_stream = stream_of();
    sdi_viol = 0; tim_bad = 0; rd_seen = 0;
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R9 busy after accept", {busy, cs_n}, 2'b10);
    while (!done && t < 5000) begin
      if (rd_valid) rd_seen++;
      @(negedge clk); t++;
    end
    check("R10 done seen", done, 1'b1);
    check("R10 rd_valid with done", rd_valid, 1'b1);
    check("R10 busy low at done", busy, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {cs_n, sck, busy, req_ready, done, rd_valid}, 6'b100100);
  endtask

  task automatic t_full_write();
    dev_sel = 3'b111;
    dev_cmd = {4'h3, 4'h0, 4'h2}; dev_addr = {4'h7, 4'h1, 4'hF};
    dev_data = {16'hA5C3, 16'h1234, 16'hFFFE};
    run_txn();
    for (int i = 0; i < N; i++) check($sformatf("R2/R3 dev%0d frame", i), dexec[i], exp_stream[i*32 +: 32]);
    check("R10 readback of reset chain", rd_frames, prev_stream);
    check("R5 edge count", rises, SW);
    check("R6 sdi stable while high", sdi_viol, 0);
    check("R7/R8 timing", tim_bad, 0);
    prev_stream = exp_stream;
  endtask

  task automatic t_partial();
    dev_sel = 3'b010;
    dev_cmd = {4'h3, 4'h1, 4'h0}; dev_addr = {4'h2, 4'h4, 4'h6};
    dev_data = {16'h0001, 16'h8000, 16'h7FFF};
    run_txn();
    check("R4 dev0 nop", dexec[0][23:20], 4'hF);
    check("R4 dev2 nop", dexec[2][23:20], 4'hF);
    check("R4 dev1 targeted", dexec[1], {8'h00, 4'h1, 4'h4, 16'h8000});
    check("R4 dev2 fields kept", dexec[2][19:0], {4'h2, 16'h0001});
    check("R10 readback previous stream", rd_frames, prev_stream);
    check("R10 single rd_valid", rd_seen, 0);
    check("R7/R8 timing partial", tim_bad, 0);
    prev_stream = exp_stream;
  endtask

  task automatic t_busy_ignore();
    logic [SW-1:0] a_stream;
    int t = 0;
    dev_sel = 3'b101;
    dev_cmd = {4'h0, 4'h2, 4'h3}; dev_addr = {4'h5, 4'h3, 4'h0};
    dev_data = {16'hBEEF, 16'h0F0F, 16'hC001};
    a_stream = stream_of();
    sdi_viol = 0; tim_bad = 0;
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (40) @(negedge clk);
    check("R9 not ready while busy", req_ready, 1'b0);
    dev_sel = 3'b111; dev_data = {16'h1111, 16'h2222, 16'h3333};
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check("R9 done of first", done, 1'b1);
    repeat (30) @(negedge clk);
    check("R9 no second transaction", {busy, cs_n}, 2'b01);
    for (int i = 0; i < N; i++) check($sformatf("R9 dev%0d frame unchanged", i), dexec[i], a_stream[i*32 +: 32]);
    check("R5 edges busy test", rises, SW);
    check("R6 sdi stable busy test", sdi_viol, 0);
    check("R8 timing busy test", tim_bad, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_full_write();
        t_partial();
        t_busy_ignore();
      end
      begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule